// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block forms the second operand of an integer ALU, together with the shifter carry that a flag-setting instruction may write back. It is purely combinational. A result is available in the same cycle as its inputs and there is no state inside the block. It has two paths.

The shifted-register path takes a 32-bit register value and shifts it by a distance. The distance comes either from a 5-bit field in the instruction or from the low byte of a second register. Five shift operations are available: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate through the carry flag. The immediate path takes an 8-bit constant and rotates it right by twice a 4-bit rotate field.

The 5-bit field has folded encodings. A right shift coded as zero means a distance of 32, and a rotate coded as zero means the rotate-through-carry. A register distance can be as large as 255, so the shifts beyond the word width are defined explicitly. Register reads and the ALU itself sit outside the block.

Because the datapath is combinational, it has no valid/ready pins. The caller samples the outputs in the same cycle, and back-pressure cannot arise.

Top module: `opsh_top`

## Requirements
- R1: With `imm_mode`=0 and `amt_from_reg`=0, shift kind 0 (logical left) with field n in 0..31 gives `value << n`. For n>0 the carry is `value[32-n]`. For n=0 the value passes unchanged and the carry equals `carry_in`.
- R2: Shift kinds 1 (logical right) and 2 (arithmetic right) with field n in 1..31 give the shifted value, zero-filled for kind 1 and sign-filled for kind 2, with carry `value[n-1]`. A field of 0 means a distance of 32.
- R3: Shift kind 3 (rotate right) with field n in 1..31 gives the value rotated right by n, with carry equal to bit 31 of the result.
- R4: Shift kind 3 with field 0 performs the rotate through carry: the result is `{carry_in, value[31:1]}` and the carry is `value[0]`.
- R5: With `amt_from_reg`=1 the distance is `shift_reg_byte`. A distance of 0 passes the value unchanged with carry `carry_in`, for every shift kind.
- R6: A register distance of exactly 32 gives 0 for logical left, with carry `value[0]`, and 0 for logical right, with carry `value[31]`.
- R7: A register distance of 33..255 for logical left or logical right gives 0 with carry 0.
- R8: A register distance of 32..255 for arithmetic right gives 32 copies of `value[31]`, with carry `value[31]`. Distances 1..31 behave as in R2.
- R9: A register rotate uses the distance mod 32. A nonzero multiple of 32 leaves the value unchanged, with carry `value[31]`.
- R10: With `imm_mode`=1 the result is `imm_byte`, zero-extended, rotated right by 2×`imm_rot`. The carry is bit 31 of the result when `imm_rot`≠0, and `carry_in` otherwise.
- R11: With `imm_mode`=1 the outputs do not depend on `value`, `shift_kind`, `shift_imm`, `shift_reg_byte` or `amt_from_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value | input | 32 | Register operand to be shifted |
| shift_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| shift_imm | input | 5 | Distance field from the instruction |
| shift_reg_byte | input | 8 | Low byte of the distance register |
| amt_from_reg | input | 1 | 1: distance from `shift_reg_byte`; 0: from `shift_imm` |
| carry_in | input | 1 | Current carry flag |
| imm_mode | input | 1 | 1: output the rotated immediate constant |
| imm_byte | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate field (half the distance) |
| result | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench sweeps every distance from 0 to 255 for every kind. It concentrates on the distances 0, 31, 32, 33 and multiples of 32, where a shifter that wraps the distance mod 32 would return the input instead of 0 or sign-fill. At those same distances, a wrong carry source would show up as the wrong last bit shifted out.

The folded immediate codes are checked directly:
- A decoder that reads a right-shift field of 0 literally would pass the value through where it should clear or sign-fill it.
- A decoder that treats a rotate field of 0 as no rotate would lose the inserted carry.

For the immediate path, the bench checks the doubling of the rotate field and the carry when the field is zero. It also changes every shifter input while `imm_mode` is high, to expose any leakage between the two paths.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

  // Encoding of the shift_kind pin (behavioural: the decoder keys on it)
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  // Internal operation after folding the immediate encodings
  typedef enum logic [2:0] {
    OP_LSL,
    OP_LSR,
    OP_ASR,
    OP_ROR,
    OP_RRX
  } shift_op_e;

endpackage

// File: rtl/opsh_rotr.sv
// Logarithmic right rotator: one mux rank per bit of the distance.
module opsh_rotr #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [0:SW];

  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_rank
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]} : stage[k];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/opsh_decode.sv
// Folds the instruction-field encodings into an operation and a plain distance.
module opsh_decode
  import opsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int SH_W  = $clog2(W)
) (
  input  shift_kind_e       kind,
  input  logic [SH_W-1:0]   imm_field,
  input  logic [AMT_W-1:0]  reg_byte,
  input  logic              from_reg,
  output shift_op_e         op,
  output logic [AMT_W-1:0]  amt
);

  always_comb begin
    case (kind)
      SK_LSL:  op = OP_LSL;
      SK_LSR:  op = OP_LSR;
      SK_ASR:  op = OP_ASR;
      default: op = OP_ROR;
    endcase
    if (from_reg) begin
      amt = reg_byte;
    end else begin
      amt = AMT_W'(imm_field);
      if (imm_field == '0) begin
        case (kind)
          SK_LSR, SK_ASR: amt = AMT_W'(W);
          SK_ROR: begin
            op  = OP_RRX;
            amt = AMT_W'(1);
          end
          default: amt = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/opsh_core.sv
// Shift datapath: one shared rotator plus masks, with range flags for
// distances at or beyond the word width.
module opsh_core
  import opsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     din,
  input  shift_op_e        op,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [W-1:0]     dout,
  output logic             cout
);

  localparam int SW = $clog2(W);

  logic [SW-1:0] s;
  logic [SW-1:0] rot_amt;
  logic [W-1:0]  rot;
  logic [W-1:0]  mask_r;
  logic [W-1:0]  mask_l;
  logic          is_zero;
  logic          is_exact;
  logic          is_big;
  logic          sign;

  assign s        = amt[SW-1:0];
  assign is_zero  = (amt == '0);
  assign is_exact = (amt == AMT_W'(W));
  assign is_big   = (amt >= AMT_W'(W));
  assign sign     = din[W-1];
  assign mask_r   = {W{1'b1}} >> s;
  assign mask_l   = {W{1'b1}} << s;
  // A left shift by s is a right rotate by (W - s) mod W
  assign rot_amt  = (op == OP_LSL) ? (SW'(0) - s) : s;

  opsh_rotr #(.W(W), .SW(SW)) u_rot (
    .din  (din),
    .amt  (rot_amt),
    .dout (rot)
  );

  always_comb begin
    dout = din;
    cout = cin;
    case (op)
      OP_LSL: begin
        if (is_big) begin
          dout = '0;
          cout = is_exact ? din[0] : 1'b0;
        end else if (!is_zero) begin
          dout = rot & mask_l;
          cout = rot[0];
        end
      end
      OP_LSR: begin
        if (is_big) begin
          dout = '0;
          cout = is_exact ? sign : 1'b0;
        end else if (!is_zero) begin
          dout = rot & mask_r;
          cout = rot[W-1];
        end
      end
      OP_ASR: begin
        if (is_big) begin
          dout = {W{sign}};
          cout = sign;
        end else if (!is_zero) begin
          dout = (rot & mask_r) | (sign ? ~mask_r : '0);
          cout = rot[W-1];
        end
      end
      OP_ROR: begin
        if (!is_zero) begin
          dout = rot;
          cout = rot[W-1];
        end
      end
      OP_RRX: begin
        dout = {cin, din[W-1:1]};
        cout = din[0];
      end
      default: ;
    endcase
  end

  // The rotate-through-carry path bypasses the rotator entirely.
  always_comb begin
    if (op == OP_RRX) begin
      assert_rrx_inserts_carry_R4: assert (dout[W-1] == cin && cout == din[0])
        else $error("rrx carry insertion broken");
    end
  end

  // Checks the range flags against the rotator output.
  always_comb begin
    if ((op == OP_LSL || op == OP_LSR) && amt > AMT_W'(W)) begin
      assert_beyond_width_clears_R7: assert (dout == '0 && !cout)
        else $error("shift beyond width not cleared");
    end
  end

endmodule

// File: rtl/opsh_top.sv
module opsh_top
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int IMMB_W = 8,
  parameter int ROT_W  = 4,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value,
  input  logic [1:0]        shift_kind,
  input  logic [SH_W-1:0]   shift_imm,
  input  logic [AMT_W-1:0]  shift_reg_byte,
  input  logic              amt_from_reg,
  input  logic              carry_in,
  input  logic              imm_mode,
  input  logic [IMMB_W-1:0] imm_byte,
  input  logic [ROT_W-1:0]  imm_rot,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);

  shift_op_e         op;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic [DATA_W-1:0] imm_res;
  logic              imm_c;
  logic [SH_W-1:0]   imm_amt;

  opsh_decode #(.W(DATA_W), .AMT_W(AMT_W), .SH_W(SH_W)) u_dec (
    .kind      (shift_kind_e'(shift_kind)),
    .imm_field (shift_imm),
    .reg_byte  (shift_reg_byte),
    .from_reg  (amt_from_reg),
    .op        (op),
    .amt       (amt)
  );

  opsh_core #(.W(DATA_W), .AMT_W(AMT_W)) u_core (
    .din  (value),
    .op   (op),
    .amt  (amt),
    .cin  (carry_in),
    .dout (sh_res),
    .cout (sh_c)
  );

  // Immediate constant: rotate right by twice the rotate field
  assign imm_amt = SH_W'({imm_rot, 1'b0});

  opsh_rotr #(.W(DATA_W), .SW(SH_W)) u_imm_rot (
    .din  (DATA_W'(imm_byte)),
    .amt  (imm_amt),
    .dout (imm_res)
  );

  assign imm_c     = (imm_rot != '0) ? imm_res[DATA_W-1] : carry_in;
  assign result    = imm_mode ? imm_res : sh_res;
  assign carry_out = imm_mode ? imm_c : sh_c;

  always_comb begin
    if (!imm_mode && amt_from_reg && shift_reg_byte == '0) begin
      assert_reg_zero_passes_R5: assert (result == value && carry_out == carry_in)
        else $error("zero register distance altered operand");
    end
    if (!imm_mode && amt_from_reg && shift_kind == 2'd2 &&
        shift_reg_byte >= AMT_W'(DATA_W)) begin
      assert_asr_sign_fill_R8: assert (result == {DATA_W{value[DATA_W-1]}} &&
                                       carry_out == value[DATA_W-1])
        else $error("arithmetic shift not sign filled");
    end
    if (imm_mode && imm_rot == '0) begin
      assert_imm_no_rot_R10: assert (result == DATA_W'(imm_byte) && carry_out == carry_in)
        else $error("unrotated immediate wrong");
    end
  end

endmodule

// File: tb/tb_opsh_top.sv
module tb_opsh_top;

  logic        clk = 1'b0;
  logic [31:0] value;
  logic [1:0]  shift_kind;
  logic [4:0]  shift_imm;
  logic [7:0]  shift_reg_byte;
  logic        amt_from_reg;
  logic        carry_in;
  logic        imm_mode;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;
  logic [31:0] result;
  logic        carry_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  opsh_top dut (
    .value(value), .shift_kind(shift_kind), .shift_imm(shift_imm),
    .shift_reg_byte(shift_reg_byte), .amt_from_reg(amt_from_reg),
    .carry_in(carry_in), .imm_mode(imm_mode), .imm_byte(imm_byte),
    .imm_rot(imm_rot), .result(result), .carry_out(carry_out)
  );

  logic [31:0] pats [0:4] = '{32'h8000_0001, 32'h7F3C_A5E1, 32'hF0F0_0F0F,
                              32'h0000_0000, 32'hFFFF_FFFF};

  // Returns {carry, result}; n is the true distance, rrx selects rotate-through-carry
  function automatic logic [32:0] ref_shift(input logic [1:0] k, input int n,
                                            input logic rrx, input logic [31:0] v,
                                            input logic cin);
    logic [63:0] f;
    int m;
    if (rrx) return {v[0], cin, v[31:1]};
    if (n == 0) return {cin, v};
    case (k)
      2'd0: begin f = {32'b0, v} << n; return {f[32], f[31:0]}; end
      2'd1: begin f = {v, 32'b0} >> n; return {f[31], f[63:32]}; end
      2'd2: begin
        m = (n > 63) ? 63 : n;
        f = $signed({v, 32'b0}) >>> m;
        return {f[31], f[63:32]};
      end
      default: begin
        m = n % 32;
        if (m == 0) return {v[31], v};
        f = {v, v} >> m;
        return {f[31], f[31:0]};
      end
    endcase
  endfunction

  function automatic logic [32:0] ref_imm(input logic [7:0] b, input logic [3:0] r,
                                          input logic cin);
    logic [63:0] f;
    f = {24'b0, b, 24'b0, b} >> (2 * r);
    return {(r != 0) ? f[31] : cin, f[31:0]};
  endfunction

  task automatic check(input string req, input logic [32:0] exp);
    checks++;
    if ({carry_out, result} !== exp) begin
      failures++;
      $display("FAIL %s: got result=%h carry=%b expected result=%h carry=%b",
               req, result, carry_out, exp[31:0], exp[32]);
    end
  endtask

  task automatic apply_shift(input logic [31:0] v, input logic [1:0] k,
                             input logic [4:0] f, input logic [7:0] rb,
                             input logic fr, input logic c);
    @(posedge clk);
    imm_mode = 1'b0; value = v; shift_kind = k; shift_imm = f;
    shift_reg_byte = rb; amt_from_reg = fr; carry_in = c;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R5 initial state", 33'd0);
  endtask

  task automatic t_imm_lsl;  // R1
    for (int p = 0; p < 5; p++)
      for (int n = 0; n < 32; n++) begin
        apply_shift(pats[p], 2'd0, 5'(n), 8'hA5, 1'b0, n[0]);
        check("R1 imm lsl", ref_shift(2'd0, n, 1'b0, pats[p], n[0]));
      end
  endtask

  task automatic t_imm_right;  // R2
    for (int k = 1; k <= 2; k++)
      for (int p = 0; p < 5; p++)
        for (int n = 0; n < 32; n++) begin
          apply_shift(pats[p], 2'(k), 5'(n), 8'h00, 1'b0, ~n[0]);
          check("R2 imm right shift", ref_shift(2'(k), (n == 0) ? 32 : n, 1'b0,
                                               pats[p], ~n[0]));
        end
  endtask

  task automatic t_imm_ror;  // R3
    for (int p = 0; p < 5; p++)
      for (int n = 1; n < 32; n++) begin
        apply_shift(pats[p], 2'd3, 5'(n), 8'h20, 1'b0, n[1]);
        check("R3 imm ror", ref_shift(2'd3, n, 1'b0, pats[p], n[1]));
      end
  endtask

  task automatic t_rrx;  // R4
    for (int p = 0; p < 5; p++)
      for (int c = 0; c < 2; c++) begin
        apply_shift(pats[p], 2'd3, 5'd0, 8'h00, 1'b0, c[0]);
        check("R4 rrx", ref_shift(2'd3, 1, 1'b1, pats[p], c[0]));
      end
  endtask

  task automatic t_reg_zero;  // R5
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 2; c++) begin
        apply_shift(32'h9ABC_DEF1, 2'(k), 5'd0, 8'd0, 1'b1, c[0]);
        check("R5 reg zero distance", {c[0], 32'h9ABC_DEF1});
        apply_shift(32'h9ABC_DEF1, 2'(k), 5'd7, 8'd0, 1'b1, c[0]);
        check("R5 imm field ignored in reg mode", {c[0], 32'h9ABC_DEF1});
      end
  endtask

  task automatic t_reg_sweep;  // R6 R7 R8 R9
    string tag;
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 5; p++)
        for (int n = 0; n < 256; n++) begin
          apply_shift(pats[p], 2'(k), 5'd0, 8'(n), 1'b1, n[2]);
          if (k == 3) tag = "R9 reg ror";
          else if (k == 2) tag = "R8 reg asr";
          else if (n == 32) tag = "R6 reg shift by 32";
          else if (n > 32) tag = "R7 reg shift beyond 32";
          else tag = "R6 reg shift below 32";
          check(tag, ref_shift(2'(k), n, 1'b0, pats[p], n[2]));
        end
  endtask

  task automatic t_imm_operand;  // R10
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 2; c++) begin
        @(posedge clk);
        imm_mode = 1'b1; imm_byte = 8'hC3; imm_rot = 4'(r); carry_in = c[0];
        @(negedge clk);
        check("R10 immediate operand", ref_imm(8'hC3, 4'(r), c[0]));
      end
  endtask

  task automatic t_imm_isolation;  // R11
    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      imm_mode = 1'b1; imm_byte = 8'h5A; imm_rot = 4'd3; carry_in = 1'b0;
      value = pats[i % 5] ^ 32'(i * 32'h1111_0000); shift_kind = 2'(i);
      shift_imm = 5'(i * 3); shift_reg_byte = 8'(i * 17); amt_from_reg = i[0];
      @(negedge clk);
      check("R11 shifter inputs ignored in immediate mode", ref_imm(8'h5A, 4'd3, 1'b0));
    end
  endtask

  initial begin
    value = '0; shift_kind = '0; shift_imm = '0; shift_reg_byte = '0;
    amt_from_reg = 1'b0; carry_in = 1'b0; imm_mode = 1'b0;
    imm_byte = '0; imm_rot = '0;
    t_reset();
    t_imm_lsl();
    t_imm_right();
    t_imm_ror();
    t_rrx();
    t_reg_zero();
    t_reg_sweep();
    t_imm_operand();
    t_imm_isolation();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule